// File: doc/BRIEF.md
# Sign-Extending Serial/Parallel Shift Register

This block is a parameterised register (eight bits by default) with three operating modes: hold, synchronous parallel load, and right shift. In right-shift mode the top bit takes either one of two serial inputs, picked by a select line, or a copy of its own previous value. The self-copy gives arithmetic sign extension, which a bit-serial two's-complement multiplier needs when it shifts a partial product.

Parallel data enters and leaves over one shared bidirectional bus. Here the bus is modelled as three signals: a separate input vector, an output vector and a drive-enable. The drive-enable goes low automatically during a parallel load, so that the bus can be sampled as an input. It also goes low whenever the active-low output enable is high. A separate two-state serial output always shows the lowest register bit. An active-low clear resets the register asynchronously.

Top module: `sxsr_top`

## Requirements
- R1: With `reg_en_n` high, the register keeps every bit unchanged on the rising clock edge, whatever the other inputs do.
- R2: With `reg_en_n` low and `shift_mode` low (parallel load), the register loads `bus_in` on the rising edge.
- R3: With `reg_en_n` low and `shift_mode` high (right shift), bit n takes the old bit n+1 for every n below the top bit, and the old bit 0 is discarded.
- R4: In right shift with `sext_n` high, the top bit loads `ser_d0` when `ser_sel` is 0 and `ser_d1` when `ser_sel` is 1.
- R5: In right shift with `sext_n` low, the top bit keeps its previous value, and `ser_sel`, `ser_d0` and `ser_d1` have no effect.
- R6: A low on `clr_n` clears the register to zero at once, without waiting for a clock edge. The register stays zero while `clr_n` is held low.
- R7: `bus_oe` is 1 exactly when `oe_n` is low and the block is not in parallel-load mode (parallel-load mode is `reg_en_n` low with `shift_mode` low). `bus_out` always carries the current register contents.
- R8: While `oe_n` is high, `bus_oe` is 0, and loading, shifting and clearing still work as in R2 to R6.
- R9: `ser_out` always equals the current register bit 0 and is never disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| reg_en_n | input | 1 | Register enable, active low; high means hold |
| shift_mode | input | 1 | 1 = shift right, 0 = parallel load |
| sext_n | input | 1 | Sign extend, active low |
| ser_sel | input | 1 | Serial source select: 0 = ser_d0, 1 = ser_d1 |
| ser_d0 | input | 1 | Serial data input 0 |
| ser_d1 | input | 1 | Serial data input 1 |
| oe_n | input | 1 | Bus output enable, active low |
| bus_in | input | WIDTH | Value received from the shared bus |
| bus_out | output | WIDTH | Register contents sent toward the bus |
| bus_oe | output | 1 | Bus drive-enable |
| ser_out | output | 1 | Two-state serial output, register bit 0 |

## Verification
A negative value is shifted eight times with sign extension active while the serial select and data lines toggle. The register must settle at all ones, and any leak from the serial inputs into the top bit shows up there. Serial fills from each data input, with the other input held at the opposite level, show whether the select picks the right source. Loads issued while the output enable is high, a hold with a changing bus, and a clear asserted between clock edges in the middle of a shift separate the gating of the enable, the mode and the clear from that of the bus driver.

// File: rtl/sxsr_pkg.sv
package sxsr_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_SHIFT = 2'd2
  } sxsr_op_e;
endpackage

// File: rtl/sxsr_decode.sv
module sxsr_decode
  import sxsr_pkg::*;
(
  input  logic     clk,
  input  logic     clr_n,
  input  logic     reg_en_n,
  input  logic     shift_mode,
  input  logic     oe_n,
  output sxsr_op_e op,
  output logic     bus_oe
);
  always_comb begin
    if (reg_en_n)       op = OP_HOLD;
    else if (shift_mode) op = OP_SHIFT;
    else                 op = OP_LOAD;
  end

  assign bus_oe = !oe_n && (op != OP_LOAD);

  AST_LOAD_RELEASES_BUS: assert property (@(posedge clk) disable iff (!clr_n)
    (!reg_en_n && !shift_mode) |-> !bus_oe); // R7
  AST_OE_FORCES_OFF: assert property (@(posedge clk) disable iff (!clr_n)
    oe_n |-> !bus_oe); // R8
  AST_DRIVE_OTHERWISE: assert property (@(posedge clk) disable iff (!clr_n)
    (!oe_n && (reg_en_n || shift_mode)) |-> bus_oe); // R7
endmodule

// File: rtl/sxsr_msb_src.sv
module sxsr_msb_src (
  input  logic clk,
  input  logic clr_n,
  input  logic shifting,
  input  logic sext_n,
  input  logic ser_sel,
  input  logic ser_d0,
  input  logic ser_d1,
  input  logic msb_now,
  output logic msb_next
);
  logic ser_pick;
  assign ser_pick = ser_sel ? ser_d1 : ser_d0;
  assign msb_next = sext_n ? ser_pick : msb_now;

  AST_SEXT_KEEPS_MSB: assert property (@(posedge clk) disable iff (!clr_n)
    (shifting && !sext_n) |-> (msb_next == msb_now)); // R5
  AST_SER_D1_SEL: assert property (@(posedge clk) disable iff (!clr_n)
    (shifting && sext_n && ser_sel) |-> (msb_next == ser_d1)); // R4
  AST_SER_D0_SEL: assert property (@(posedge clk) disable iff (!clr_n)
    (shifting && sext_n && !ser_sel) |-> (msb_next == ser_d0)); // R4
endmodule

// File: rtl/sxsr_core.sv
module sxsr_core
  import sxsr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  sxsr_op_e         op,
  input  logic             msb_next,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] q
);
  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] q_next;

  always_comb begin
    unique case (op)
      OP_LOAD:  q_next = par_in;
      OP_SHIFT: q_next = {msb_next, q[TOP:1]};
      default:  q_next = q;
    endcase
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q <= '0;
    else        q <= q_next;
  end

  AST_CLEARED: assert property (@(posedge clk) !clr_n |-> (q == '0)); // R6
  AST_HOLD: assert property (@(posedge clk) disable iff (!clr_n)
    (op == OP_HOLD) |=> $stable(q)); // R1
  AST_LOAD: assert property (@(posedge clk) disable iff (!clr_n)
    (op == OP_LOAD) |=> (q == $past(par_in))); // R2
  AST_SHIFT_LOW: assert property (@(posedge clk) disable iff (!clr_n)
    (op == OP_SHIFT) |=> (q[TOP-1:0] == $past(q[TOP:1]))); // R3
endmodule

// File: rtl/sxsr_top.sv
module sxsr_top
  import sxsr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             reg_en_n,
  input  logic             shift_mode,
  input  logic             sext_n,
  input  logic             ser_sel,
  input  logic             ser_d0,
  input  logic             ser_d1,
  input  logic             oe_n,
  input  logic [WIDTH-1:0] bus_in,
  output logic [WIDTH-1:0] bus_out,
  output logic             bus_oe,
  output logic             ser_out
);
  sxsr_op_e         op;
  logic             msb_next;
  logic [WIDTH-1:0] q;

  sxsr_decode u_decode (
    .clk(clk), .clr_n(clr_n), .reg_en_n(reg_en_n), .shift_mode(shift_mode),
    .oe_n(oe_n), .op(op), .bus_oe(bus_oe)
  );

  sxsr_msb_src u_msb (
    .clk(clk), .clr_n(clr_n), .shifting(op == OP_SHIFT), .sext_n(sext_n),
    .ser_sel(ser_sel), .ser_d0(ser_d0), .ser_d1(ser_d1),
    .msb_now(q[WIDTH-1]), .msb_next(msb_next)
  );

  sxsr_core #(.WIDTH(WIDTH)) u_core (
    .clk(clk), .clr_n(clr_n), .op(op), .msb_next(msb_next),
    .par_in(bus_in), .q(q)
  );

  assign bus_out = q;
  assign ser_out = q[0];

  AST_SER_OUT_SHIFTS: assert property (@(posedge clk) disable iff (!clr_n)
    (!reg_en_n && shift_mode) |=> (ser_out == $past(bus_out[1]))); // R9
endmodule

// File: tb/sxsr_top_bench.sv
module sxsr_top_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  logic clr_n, reg_en_n, shift_mode, sext_n, ser_sel, ser_d0, ser_d1, oe_n;
  logic [W-1:0] bus_in, bus_out;
  logic bus_oe, ser_out;

  int vectors = 0;
  int miscompares = 0;
  logic [W-1:0] model;

  always #5 clk = ~clk;

  sxsr_top #(.WIDTH(W)) u_sxsr_top (
    .clk(clk), .clr_n(clr_n), .reg_en_n(reg_en_n), .shift_mode(shift_mode),
    .sext_n(sext_n), .ser_sel(ser_sel), .ser_d0(ser_d0), .ser_d1(ser_d1),
    .oe_n(oe_n), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .ser_out(ser_out)
  );

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_oe();
    return !oe_n && !(!reg_en_n && !shift_mode);
  endfunction

  // Drive one cycle's controls at the falling edge, predict, clock, compare.
  task automatic cyc(logic en_n, logic sh, logic sx_n, logic sel, logic d0,
                     logic d1, logic oen, logic [W-1:0] din, string req);
    reg_en_n = en_n; shift_mode = sh; sext_n = sx_n; ser_sel = sel;
    ser_d0 = d0; ser_d1 = d1; oe_n = oen; bus_in = din;
    #1;
    chk({req, "/R7 bus_oe"}, int'(bus_oe), int'(exp_oe()));
    if (!en_n) begin
      if (sh) model = {(sx_n ? (sel ? d1 : d0) : model[W-1]), model[W-1:1]};
      else    model = din;
    end
    @(posedge clk);
    @(negedge clk);
    chk({req, " reg"}, int'(bus_out), int'(model));
    chk({req, "/R9 ser_out"}, int'(ser_out), int'(model[0]));
  endtask

  initial begin
    #(10 * 200000);
    miscompares++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    clr_n = 1'b0; reg_en_n = 1'b1; shift_mode = 1'b0; sext_n = 1'b1;
    ser_sel = 1'b0; ser_d0 = 1'b0; ser_d1 = 1'b0; oe_n = 1'b0; bus_in = '0;
    model = '0;
    repeat (2) @(negedge clk);
    chk("R6 reset", int'(bus_out), 0);
    chk("R9 reset", int'(ser_out), 0);
    clr_n = 1'b1;

    cyc(0, 0, 1, 0, 0, 0, 0, 8'h96, "R2 load");
    cyc(1, 0, 1, 1, 1, 1, 0, 8'h3C, "R1 hold load-mode");
    cyc(1, 1, 0, 0, 1, 1, 0, 8'h00, "R1 hold shift-mode");
    // R5: 8-step sign-extended shift of 0x96, serial lines toggling
    for (int i = 0; i < W; i++)
      cyc(0, 1, 0, i[0], ~i[1], i[1], 0, 8'h00, "R5 sext");
    chk("R5 final ones", int'(bus_out), 8'hFF);

    cyc(0, 0, 1, 0, 0, 0, 0, 8'h5A, "R2 load");
    for (int i = 0; i < W; i++)
      cyc(0, 1, 1, 0, 1, 0, 0, 8'h00, "R4 fill d0 R3");
    chk("R4 d0 fill", int'(bus_out), 8'hFF);
    cyc(0, 0, 1, 0, 0, 0, 0, 8'hA5, "R2 load");
    for (int i = 0; i < W; i++)
      cyc(0, 1, 1, 1, 0, 1, 0, 8'h00, "R4 fill d1 R3");
    chk("R4 d1 fill", int'(bus_out), 8'hFF);
    for (int i = 0; i < 4; i++)
      cyc(0, 1, 1, 1, 1, 0, 0, 8'h00, "R4 d1 zeros");
    chk("R4 d1 zeros", int'(bus_out), 8'h0F);

    // R8: loads and shifts with the bus disabled
    cyc(0, 0, 1, 0, 0, 0, 1, 8'hC3, "R8 load oe_n high");
    cyc(0, 1, 0, 0, 0, 0, 1, 8'h00, "R8 sext oe_n high");
    cyc(1, 1, 1, 0, 0, 0, 1, 8'h00, "R8 hold oe_n high");

    // R6: clear asserted between edges in the middle of a shift
    cyc(0, 0, 1, 0, 0, 0, 0, 8'h7E, "R2 load");
    cyc(0, 1, 1, 0, 1, 0, 0, 8'h00, "R3 shift");
    cyc(0, 1, 1, 0, 1, 0, 0, 8'h00, "R3 shift");
    #2 clr_n = 1'b0;
    #1;
    chk("R6 async clear", int'(bus_out), 0);
    chk("R6 ser_out clear", int'(ser_out), 0);
    model = '0;
    @(posedge clk);
    @(negedge clk);
    chk("R6 held clear", int'(bus_out), 0);
    clr_n = 1'b1;
    cyc(0, 1, 1, 0, 1, 0, 0, 8'h00, "R4 after clear");
    chk("R4 after clear", int'(bus_out), 8'h80);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule